// File: doc/BRIEF.md
# Shrinking Center Locator

This block finds the centres of two blobs in a small grey-level image frame. One blob is a bright spot and the other a dark disc. Every pixel compares its sample against two thresholds, giving a "bright" flag plane and a "dark" flag plane. Each plane then goes through a short noise-removal opening: a fixed number of parallel shrink steps, then the same number of parallel grow steps.

After the opening, the plane is shrunk once per clock. This continues until the next shrink would leave no pixel set. OR-projection lines over rows and columns detect that moment without scanning the array. The pixels still set at that point are the survivors. Priority encoders on their projections give the blob's column and row.

Both planes run at the same time. Each plane finishes on its own. A single completion flag rises once both planes have results. A start pulse loads the frame and both thresholds. Results then hold until the next accepted start.

Top module: `shrink_center_locator`

## Requirements
- R1: The pixel at column x, row y is `frame_i[(y*COLS+x)*8 +: 8]`. Its bright flag is set when the sample is greater than or equal to `glint_thr_i`. Its dark flag is set when the sample is less than or equal to `pupil_thr_i`.
- R2: Before the centre search, each plane receives OPEN_STEPS (default 1) shrink steps and then OPEN_STEPS grow steps. With the default of 1, a lone set pixel is erased and leaves the plane empty.
- R3: In a shrink step, a set pixel stays set only if all four orthogonal neighbours are set. Neighbours outside the array count as clear. In a grow step, a pixel becomes set if it or any orthogonal neighbour is set.
- R4: The search shrinks the plane step by step. It stops on the step that would empty the plane, and the plane before that step is kept as the survivors. The reported x is the lowest column, and y the lowest row, holding any survivor.
- R5: The reported iteration count is the number of search steps that left the plane non-empty. It never exceeds MAX_ITER, which is half the smaller array dimension.
- R6: The valid output of a plane is 1 only if that plane is non-empty when the search begins. When valid is 0, that plane's x, y and iteration count are 0.
- R7: `done_o` is 0 after reset. It falls in the cycle after a start is accepted. It rises only after both planes have finished. While no start is accepted, `done_o` and all results hold.
- R8: A start pulse that arrives while either plane is still working is ignored. The run in progress completes with its own frame.
- R9: The two planes are processed independently. Each plane's results depend only on its own flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; loads frame and thresholds when idle |
| frame_i | input | COLS*ROWS*PIX_W | Pixel samples, row-major |
| glint_thr_i | input | PIX_W | Bright-blob threshold (sample >= threshold) |
| pupil_thr_i | input | PIX_W | Dark-blob threshold (sample <= threshold) |
| done_o | output | 1 | Both planes have results |
| glint_valid_o | output | 1 | Bright plane held a blob |
| glint_x_o | output | $clog2(COLS) | Bright blob centre column |
| glint_y_o | output | $clog2(ROWS) | Bright blob centre row |
| glint_iter_o | output | $clog2(MAX_ITER+1) | Bright plane search steps |
| pupil_valid_o | output | 1 | Dark plane held a blob |
| pupil_x_o | output | $clog2(COLS) | Dark blob centre column |
| pupil_y_o | output | $clog2(ROWS) | Dark blob centre row |
| pupil_iter_o | output | $clog2(MAX_ITER+1) | Dark plane search steps |

## Verification
Two events can fall in the same cycle: the two planes reaching extinction, and the joint completion that waits on both. A vector with blobs of equal erosion depth in both planes makes both engines finish on the same edge. Other vectors give the planes different depths, or leave one plane empty, so the planes finish on different edges. In every case the bench checks that the two coordinate sets, validity flags and step counts match hand-derived values once `done_o` rises.

A second coincidence is a start pulse held into the cycle after acceptance, while the engines are busy. It is judged by confirming that the results belong to the first frame and not the second.

// File: rtl/slc_pkg.sv
package slc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPEN_E,
    ST_OPEN_D,
    ST_SEARCH,
    ST_DONE
  } eng_state_t;

  typedef enum logic {
    MORPH_ERODE,
    MORPH_DILATE
  } morph_op_t;
endpackage

// File: rtl/slc_threshold.sv
module slc_threshold #(
  parameter int COLS  = 8,
  parameter int ROWS  = 8,
  parameter int PIX_W = 8,
  localparam int N    = COLS * ROWS
) (
  input  logic [N*PIX_W-1:0] frame_i,
  input  logic [PIX_W-1:0]   thr_bright_i,
  input  logic [PIX_W-1:0]   thr_dark_i,
  output logic [N-1:0]       bright_o,
  output logic [N-1:0]       dark_o
);
  for (genvar i = 0; i < N; i++) begin : g_pix
    assign bright_o[i] = frame_i[i*PIX_W +: PIX_W] >= thr_bright_i;
    assign dark_o[i]   = frame_i[i*PIX_W +: PIX_W] <= thr_dark_i;
  end
endmodule

// File: rtl/slc_morph.sv
module slc_morph #(
  parameter int COLS = 8,
  parameter int ROWS = 8,
  parameter slc_pkg::morph_op_t OP = slc_pkg::MORPH_ERODE,
  localparam int N = COLS * ROWS
) (
  input  logic [N-1:0] plane_i,
  output logic [N-1:0] plane_o
);
  for (genvar y = 0; y < ROWS; y++) begin : g_row
    for (genvar x = 0; x < COLS; x++) begin : g_col
      localparam int IDX = y * COLS + x;
      logic n_up, n_dn, n_lf, n_rt;
      if (y > 0) begin : g_up
        assign n_up = plane_i[IDX-COLS];
      end else begin : g_up0
        assign n_up = 1'b0;
      end
      if (y < ROWS - 1) begin : g_dn
        assign n_dn = plane_i[IDX+COLS];
      end else begin : g_dn0
        assign n_dn = 1'b0;
      end
      if (x > 0) begin : g_lf
        assign n_lf = plane_i[IDX-1];
      end else begin : g_lf0
        assign n_lf = 1'b0;
      end
      if (x < COLS - 1) begin : g_rt
        assign n_rt = plane_i[IDX+1];
      end else begin : g_rt0
        assign n_rt = 1'b0;
      end
      if (OP == slc_pkg::MORPH_ERODE) begin : g_er
        assign plane_o[IDX] = plane_i[IDX] & n_up & n_dn & n_lf & n_rt;
      end else begin : g_di
        assign plane_o[IDX] = plane_i[IDX] | n_up | n_dn | n_lf | n_rt;
      end
    end
  end
endmodule

// File: rtl/slc_projection.sv
module slc_projection #(
  parameter int COLS = 8,
  parameter int ROWS = 8,
  localparam int N = COLS * ROWS
) (
  input  logic [N-1:0]    plane_i,
  output logic [ROWS-1:0] row_proj_o,
  output logic [COLS-1:0] col_proj_o
);
  for (genvar y = 0; y < ROWS; y++) begin : g_rp
    assign row_proj_o[y] = |plane_i[y*COLS +: COLS];
  end
  for (genvar x = 0; x < COLS; x++) begin : g_cp
    logic [ROWS-1:0] column;
    for (genvar y = 0; y < ROWS; y++) begin : g_cb
      assign column[y] = plane_i[y*COLS + x];
    end
    assign col_proj_o[x] = |column;
  end
endmodule

// File: rtl/slc_plane_engine.sv
module slc_plane_engine #(
  parameter int COLS       = 8,
  parameter int ROWS       = 8,
  parameter int OPEN_STEPS = 1,
  parameter int MAX_ITER   = 4,
  localparam int N  = COLS * ROWS,
  localparam int XW = $clog2(COLS),
  localparam int YW = $clog2(ROWS),
  localparam int IW = $clog2(MAX_ITER + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [N-1:0]  plane_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          valid_o,
  output logic [XW-1:0] x_o,
  output logic [YW-1:0] y_o,
  output logic [IW-1:0] iter_o
);
  import slc_pkg::*;

  localparam int CW = $clog2(OPEN_STEPS + 2);
  localparam logic [CW-1:0] STEP_LAST = CW'(OPEN_STEPS > 0 ? OPEN_STEPS - 1 : 0);
  localparam logic [IW-1:0] ITER_CAP  = IW'(MAX_ITER);

  eng_state_t    state_q;
  logic [N-1:0]  cur_q;
  logic [CW-1:0] step_q;
  logic [IW-1:0] iter_q;
  logic          done_q, valid_q;
  logic [XW-1:0] x_q;
  logic [YW-1:0] y_q;
  logic [IW-1:0] it_q;

  logic [N-1:0]    eroded, grown;
  logic [ROWS-1:0] row_cur, row_er;
  logic [COLS-1:0] col_cur, col_er;
  logic            any_cur, any_er;
  logic [XW-1:0]   x_enc;
  logic [YW-1:0]   y_enc;

  slc_morph #(.COLS(COLS), .ROWS(ROWS), .OP(MORPH_ERODE)) u_erode (
    .plane_i(cur_q), .plane_o(eroded));
  slc_morph #(.COLS(COLS), .ROWS(ROWS), .OP(MORPH_DILATE)) u_grow (
    .plane_i(cur_q), .plane_o(grown));
  slc_projection #(.COLS(COLS), .ROWS(ROWS)) u_proj_cur (
    .plane_i(cur_q), .row_proj_o(row_cur), .col_proj_o(col_cur));
  slc_projection #(.COLS(COLS), .ROWS(ROWS)) u_proj_er (
    .plane_i(eroded), .row_proj_o(row_er), .col_proj_o(col_er));

  assign any_cur = |row_cur;
  assign any_er  = |row_er;

  always_comb begin
    x_enc = '0;
    for (int i = COLS - 1; i >= 0; i--) begin
      if (col_cur[i]) x_enc = XW'(i);
    end
    y_enc = '0;
    for (int j = ROWS - 1; j >= 0; j--) begin
      if (row_cur[j]) y_enc = YW'(j);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      step_q  <= '0;
      iter_q  <= '0;
      done_q  <= 1'b0;
      valid_q <= 1'b0;
      x_q     <= '0;
      y_q     <= '0;
      it_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE, ST_DONE: begin
          if (load_i) begin
            cur_q   <= plane_i;
            step_q  <= '0;
            iter_q  <= '0;
            done_q  <= 1'b0;
            state_q <= (OPEN_STEPS > 0) ? ST_OPEN_E : ST_SEARCH;
          end
        end
        ST_OPEN_E: begin
          cur_q <= eroded;
          if (step_q == STEP_LAST) begin
            step_q  <= '0;
            state_q <= ST_OPEN_D;
          end else begin
            step_q <= step_q + 1'b1;
          end
        end
        ST_OPEN_D: begin
          cur_q <= grown;
          if (step_q == STEP_LAST) begin
            step_q  <= '0;
            state_q <= ST_SEARCH;
          end else begin
            step_q <= step_q + 1'b1;
          end
        end
        ST_SEARCH: begin
          if (!any_cur || !any_er || iter_q == ITER_CAP) begin
            valid_q <= any_cur;
            x_q     <= x_enc;
            y_q     <= y_enc;
            it_q    <= iter_q;
            done_q  <= 1'b1;
            state_q <= ST_DONE;
          end else begin
            cur_q  <= eroded;
            iter_q <= iter_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o  = (state_q == ST_OPEN_E) || (state_q == ST_OPEN_D) ||
                   (state_q == ST_SEARCH);
  assign done_o  = done_q;
  assign valid_o = valid_q;
  assign x_o     = x_q;
  assign y_o     = y_q;
  assign iter_o  = it_q;

  // R5
  iter_cap_chk: assert property (@(posedge clk) disable iff (rst)
    iter_q <= ITER_CAP);

  // R4
  survivor_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SEARCH && any_cur) |=> any_cur);

  // R6
  invalid_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (done_q && !valid_q) |-> (x_q == '0 && y_q == '0 && it_q == '0));

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done_q && !load_i) |=> (done_q && $stable(x_q) && $stable(y_q) &&
                             $stable(it_q) && $stable(valid_q)));

  // R3
  proj_agree_chk: assert property (@(posedge clk) disable iff (rst)
    (|row_er) == (|col_er));
endmodule

// File: rtl/shrink_center_locator.sv
module shrink_center_locator #(
  parameter int COLS       = 8,
  parameter int ROWS       = 8,
  parameter int PIX_W      = 8,
  parameter int OPEN_STEPS = 1,
  localparam int N        = COLS * ROWS,
  localparam int MAX_ITER = ((COLS < ROWS) ? COLS : ROWS) / 2,
  localparam int XW       = $clog2(COLS),
  localparam int YW       = $clog2(ROWS),
  localparam int IW       = $clog2(MAX_ITER + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [N*PIX_W-1:0] frame_i,
  input  logic [PIX_W-1:0]   glint_thr_i,
  input  logic [PIX_W-1:0]   pupil_thr_i,
  output logic               done_o,
  output logic               glint_valid_o,
  output logic [XW-1:0]      glint_x_o,
  output logic [YW-1:0]      glint_y_o,
  output logic [IW-1:0]      glint_iter_o,
  output logic               pupil_valid_o,
  output logic [XW-1:0]      pupil_x_o,
  output logic [YW-1:0]      pupil_y_o,
  output logic [IW-1:0]      pupil_iter_o
);
  logic [N-1:0] bright_plane, dark_plane;
  logic         g_busy, p_busy, g_done, p_done;
  logic         accept;
  logic         done_q;

  slc_threshold #(.COLS(COLS), .ROWS(ROWS), .PIX_W(PIX_W)) u_thr (
    .frame_i(frame_i), .thr_bright_i(glint_thr_i), .thr_dark_i(pupil_thr_i),
    .bright_o(bright_plane), .dark_o(dark_plane));

  assign accept = start_i && !g_busy && !p_busy;

  slc_plane_engine #(.COLS(COLS), .ROWS(ROWS), .OPEN_STEPS(OPEN_STEPS),
                     .MAX_ITER(MAX_ITER)) u_glint (
    .clk(clk), .rst(rst), .load_i(accept), .plane_i(bright_plane),
    .busy_o(g_busy), .done_o(g_done), .valid_o(glint_valid_o),
    .x_o(glint_x_o), .y_o(glint_y_o), .iter_o(glint_iter_o));

  slc_plane_engine #(.COLS(COLS), .ROWS(ROWS), .OPEN_STEPS(OPEN_STEPS),
                     .MAX_ITER(MAX_ITER)) u_pupil (
    .clk(clk), .rst(rst), .load_i(accept), .plane_i(dark_plane),
    .busy_o(p_busy), .done_o(p_done), .valid_o(pupil_valid_o),
    .x_o(pupil_x_o), .y_o(pupil_y_o), .iter_o(pupil_iter_o));

  always_ff @(posedge clk) begin
    if (rst) done_q <= 1'b0;
    else     done_q <= accept ? 1'b0 : (g_done && p_done);
  end

  assign done_o = done_q;

  // R7
  done_join_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (g_done && p_done));

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && (g_busy || p_busy)) |=> !done_q);
endmodule

// File: tb/shrink_center_locator_bench.sv
`timescale 1ns/1ps
module shrink_center_locator_bench;
  localparam int COLS = 8;
  localparam int ROWS = 8;
  localparam int N    = COLS * ROWS;

  typedef struct packed {
    logic [3:0] gr0, gc0, gr1, gc1;
    logic [3:0] pr0, pc0, pr1, pc1;
    logic [7:0] tg, tp;
    logic [3:0] gx, gy, git;
    logic       gv;
    logic [3:0] px, py, pit;
    logic       pv;
  } vec_t;

  // rect rows r0..r1, cols c0..c1; r0=15,r1=0 means no rect
  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{4'd2,4'd3,4'd4,4'd5, 4'd6,4'd0,4'd6,4'd0, 8'hC0,8'h40, 4'd4,4'd3,4'd1,1'b1, 4'd0,4'd0,4'd0,1'b0},
    '{4'd4,4'd4,4'd7,4'd7, 4'd0,4'd0,4'd2,4'd2, 8'hC0,8'h40, 4'd5,4'd5,4'd1,1'b1, 4'd1,4'd1,4'd1,1'b1},
    '{4'd15,4'd0,4'd0,4'd0, 4'd1,4'd1,4'd5,4'd5, 8'hC0,8'h40, 4'd0,4'd0,4'd0,1'b0, 4'd3,4'd3,4'd2,1'b1},
    '{4'd0,4'd0,4'd7,4'd7, 4'd15,4'd0,4'd0,4'd0, 8'hC0,8'h40, 4'd3,4'd3,4'd3,1'b1, 4'd0,4'd0,4'd0,1'b0},
    '{4'd0,4'd7,4'd0,4'd7, 4'd0,4'd0,4'd3,4'd3, 8'hC0,8'h40, 4'd0,4'd0,4'd0,1'b0, 4'd1,4'd1,4'd1,1'b1},
    '{4'd2,4'd3,4'd4,4'd5, 4'd4,4'd0,4'd6,4'd2, 8'hF0,8'h10, 4'd4,4'd3,4'd1,1'b1, 4'd1,4'd5,4'd1,1'b1},
    '{4'd2,4'd3,4'd4,4'd5, 4'd4,4'd0,4'd6,4'd2, 8'hF1,8'h0F, 4'd0,4'd0,4'd0,1'b0, 4'd0,4'd0,4'd0,1'b0}
  };

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic [N*8-1:0] frame = '0;
  logic [7:0]     tg = 8'h00, tp = 8'h00;
  logic           done;
  logic           gv, pv;
  logic [2:0]     gx, gy, px, py, git, pit;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  shrink_center_locator u_shrink_center_locator (
    .clk(clk), .rst(rst), .start_i(start), .frame_i(frame),
    .glint_thr_i(tg), .pupil_thr_i(tp), .done_o(done),
    .glint_valid_o(gv), .glint_x_o(gx), .glint_y_o(gy), .glint_iter_o(git),
    .pupil_valid_o(pv), .pupil_x_o(px), .pupil_y_o(py), .pupil_iter_o(pit));

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic load_vec(int k);
    vec_t v = VECS[k];
    for (int y = 0; y < ROWS; y++) begin
      for (int x = 0; x < COLS; x++) begin
        logic [7:0] s = 8'h80;
        if (y >= v.gr0 && y <= v.gr1 && x >= v.gc0 && x <= v.gc1) s = 8'hF0;
        if (y >= v.pr0 && y <= v.pr1 && x >= v.pc0 && x <= v.pc1) s = 8'h10;
        frame[(y*COLS+x)*8 +: 8] = s;
      end
    end
    tg = v.tg;
    tp = v.tp;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 300) begin
      @(negedge clk);
      n++;
    end
    check("R7", "done reached", int'(done), 1);
  endtask

  task automatic check_results(int k, string tag);
    vec_t v = VECS[k];
    check(tag, "glint valid", int'(gv),  int'(v.gv));
    check(tag, "glint x",     int'(gx),  int'(v.gx));
    check(tag, "glint y",     int'(gy),  int'(v.gy));
    check(tag, "glint iter",  int'(git), int'(v.git));
    check(tag, "pupil valid", int'(pv),  int'(v.pv));
    check(tag, "pupil x",     int'(px),  int'(v.px));
    check(tag, "pupil y",     int'(py),  int'(v.py));
    check(tag, "pupil iter",  int'(pit), int'(v.pit));
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [2:0] hx, hy;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7 reset state
    check("R7", "reset done", int'(done), 0);
    check("R6", "reset glint valid", int'(gv), 0);
    check("R6", "reset pupil valid", int'(pv), 0);
    check("R6", "reset glint x", int'(gx), 0);

    // table walk: R1 R2 R3 R4 R5 R6 R9
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      load_vec(k);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R7", "done low after start", int'(done), 0);
      wait_done();
      check_results(k, "R4");
    end

    // R8: second start during busy is ignored
    @(negedge clk);
    load_vec(1);
    start = 1'b1;
    @(negedge clk);
    check("R7", "done cleared by start", int'(done), 0);
    load_vec(2);
    @(negedge clk);
    start = 1'b0;
    wait_done();
    check_results(1, "R8");

    // R7: results hold with no accepted start
    hx = gx;
    hy = gy;
    load_vec(3);
    repeat (8) @(negedge clk);
    check("R7", "done held", int'(done), 1);
    check("R7", "glint x held", int'(gx), int'(hx));
    check("R7", "glint y held", int'(gy), int'(hy));

    // R2: lone pixel erased on its own (vector 0 pupil)
    @(negedge clk);
    load_vec(0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    check("R2", "lone pixel removed", int'(pv), 0);

    summary();
  end
endmodule